// File: doc/BRIEF.md
# Character LCD Row Scan Engine

This block produces the time-multiplexed drive sequence for a character display of up to four text lines, each twelve cells wide, with cells five dots across and eight dots tall. A mode input picks how many lines are active. The block then walks through the matching number of common rows. A frame consists of one icon row, eight raster rows for every active line, and a second icon row.

During each row period the block works through the twelve columns, one per clock. For each column it reads a character code from an external display RAM and forms a glyph store address from that code and the current raster index. It then shifts the returned five-dot slice into a 60-bit register. On the two icon rows the slices come from an eight-entry icon RAM instead. At the row boundary the register is copied to the segment outputs, and the matching common is selected one-hot. Both stay steady for the whole of the following row period.

A raster-granular vertical scroll offset and a double-height mode change which source line and raster feed each glyph common. A display-enable input blanks the segments but leaves the scan running.

Top module: `lcd_row_scan`

## Requirements
- R1: While rst is high, and after reset until the first row boundary, seg_out and com_out are all zero.
- R2: seg_out and com_out change only at row boundaries, which occur once every ROW_CYCLES clocks. After every boundary exactly one bit of com_out is set.
- R3: Let line_sel be k, so the display shows L = k+1 lines. The frame then has 8L+2 rows, scanned in this order: top icon common com_out[32], glyph commons com_out[0] up to com_out[8L-1], bottom icon common com_out[33], then back to the top icon row. This gives duties of 1/10, 1/18, 1/26 and 1/34.
- R4: On a glyph row, each column c from 0 to 11 is read at dd_addr = 12*line + c. Bits [5c+4:5c] of seg_out hold the glyph slice returned for that column's code at the row's raster index.
- R5: A code of 0 to 3 reads the user glyph RAM: glyph_user = 1 and glyph_addr = {code[1:0], raster}, zero-extended. Any other code reads the fixed table: glyph_user = 0, with the code in glyph_addr[10:3] and the raster in glyph_addr[2:0].
- R6: On both icon rows, seg_out[5k+4:5k] equals icon_bits read at icon_addr = k, for k from 0 to 7. Bits 59:40 are zero.
- R7: Glyph common g shows source raster s = (g + scroll) mod 32, meaning line s/8 at raster s mod 8. The source line may lie beyond the selected line count.
- R8: With dbl_en high and dbl_line = p, any source raster s whose line is p or p+1 is replaced by line p at raster (s - 8p)/2. All other rasters are unchanged.
- R9: If disp_on is low at a row boundary, seg_out is all zero for that row period, while the commons keep their normal sequence.
- R10: A change of line_sel takes effect at the next row boundary. If a row index is above 8L after the line count shrinks, that row is driven as the bottom icon row, and the scan then wraps to the top icon row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_sel | input | 2 | Active line count minus one |
| disp_on | input | 1 | Display enable; low blanks the segments |
| scroll | input | 5 | Vertical scroll offset in raster rows |
| dbl_en | input | 1 | Double-height enable |
| dbl_line | input | 2 | Source line stretched over two line heights |
| dd_addr | output | 6 | Display RAM read address |
| dd_code | input | 8 | Character code returned by the display RAM |
| glyph_user | output | 1 | High selects the user glyph RAM, low the fixed table |
| glyph_addr | output | 11 | Glyph store read address |
| glyph_bits | input | 5 | Dot slice returned by the glyph store |
| icon_addr | output | 3 | Icon RAM read address |
| icon_bits | input | 5 | Dot slice returned by the icon RAM |
| seg_out | output | 60 | Latched segment data for the current row |
| com_out | output | 34 | One-hot common select: [31:0] glyph rows, [32] top icon, [33] bottom icon |

## Verification
The bench uses the default geometry: four lines, twelve columns, eight rasters per cell and eight icon entries. This puts the full 34-row frame, every line mode, scroll wrap across the 32-raster source space and double-height on the last line within reach. ROW_CYCLES is cut to 14, just above the twelve shift clocks. That keeps each row short, so many complete frames, mode shrinks that land mid-frame and blank/unblank transitions fit in a few thousand clocks.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;

    localparam int DEF_COLS      = 12;
    localparam int DEF_CELL_W    = 5;
    localparam int DEF_CELL_H    = 8;
    localparam int DEF_LINES     = 4;
    localparam int DEF_ICONS     = 8;
    localparam int DEF_USER      = 4;
    localparam int DEF_CODE_W    = 8;
    localparam int DEF_ROW_CYC   = 20;

    // width of the scan position fields carried between modules
    localparam int POS_W = 8;

    typedef enum logic [1:0] {
        ROW_ICON_TOP = 2'd0,
        ROW_GLYPH    = 2'd1,
        ROW_ICON_BOT = 2'd2
    } row_kind_e;

    typedef struct packed {
        row_kind_e        kind;
        logic [POS_W-1:0] glyph_row;
        logic [POS_W-1:0] col;
        logic             shift_en;
        logic             tick;
    } scan_pos_t;

    // rows in a frame: rasters of all active lines plus two icon rows
    function automatic int frame_rows(input int lines, input int cell_h);
        return lines * cell_h + 2;
    endfunction

endpackage

// File: rtl/lcdscan_timing.sv
module lcdscan_timing import lcdscan_pkg::*; #(
    parameter int COLS       = DEF_COLS,
    parameter int CELL_H     = DEF_CELL_H,
    parameter int MAX_LINES  = DEF_LINES,
    parameter int ROW_CYCLES = DEF_ROW_CYC,
    localparam int LSEL_W    = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1,
    localparam int COM_W     = MAX_LINES * CELL_H + 2,
    localparam int ROW_W     = $clog2(COM_W),
    localparam int CW        = $clog2(ROW_CYCLES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LSEL_W-1:0] line_sel,
    output scan_pos_t         pos
);

    logic [CW-1:0]    timer_q;
    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] last_row;
    logic [ROW_W-1:0] last_glyph;
    logic             tick;

    always_comb begin
        last_glyph = ROW_W'((int'(line_sel) + 1) * CELL_H);
        last_row   = ROW_W'(frame_rows(int'(line_sel) + 1, CELL_H) - 1);
    end

    assign tick = (timer_q == CW'(ROW_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q <= '0;
            row_q   <= '0;
        end else if (tick) begin
            timer_q <= '0;
            row_q   <= (row_q >= last_row) ? '0 : row_q + 1'b1;
        end else begin
            timer_q <= timer_q + 1'b1;
        end
    end

    always_comb begin
        pos.tick     = tick;
        pos.col      = POS_W'(timer_q);
        pos.shift_en = (int'(timer_q) < COLS);
        if (row_q == '0) begin
            pos.kind      = ROW_ICON_TOP;
            pos.glyph_row = '0;
        end else if (row_q <= last_glyph) begin
            pos.kind      = ROW_GLYPH;
            pos.glyph_row = POS_W'(row_q - 1'b1);
        end else begin
            pos.kind      = ROW_ICON_BOT;
            pos.glyph_row = '0;
        end
    end

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && row_q >= last_row) |=> (row_q == '0));

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/lcdscan_addr.sv
module lcdscan_addr import lcdscan_pkg::*; #(
    parameter int COLS        = DEF_COLS,
    parameter int CELL_H      = DEF_CELL_H,
    parameter int MAX_LINES   = DEF_LINES,
    parameter int CODE_W      = DEF_CODE_W,
    parameter int USER_GLYPHS = DEF_USER,
    localparam int LSEL_W     = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1,
    localparam int GLYPH_ROWS = MAX_LINES * CELL_H,
    localparam int GR_W       = $clog2(GLYPH_ROWS),
    localparam int RAS_W      = $clog2(CELL_H),
    localparam int DD_AW      = $clog2(MAX_LINES * COLS),
    localparam int GA_W       = CODE_W + RAS_W,
    localparam int UG_W       = (USER_GLYPHS > 1) ? $clog2(USER_GLYPHS) : 1
) (
    input  logic [POS_W-1:0]  glyph_row,
    input  logic [POS_W-1:0]  col,
    input  logic              shift_en,
    input  logic [GR_W-1:0]   scroll,
    input  logic              dbl_en,
    input  logic [LSEL_W-1:0] dbl_line,
    input  logic [CODE_W-1:0] dd_code,
    output logic [DD_AW-1:0]  dd_addr,
    output logic              glyph_user,
    output logic [GA_W-1:0]   glyph_addr
);

    int src;
    int line;
    int ras;

    // visible glyph row -> source line and raster
    always_comb begin
        src = int'(glyph_row) + int'(scroll);
        if (src >= GLYPH_ROWS) src = src - GLYPH_ROWS;
        line = src / CELL_H;
        ras  = src % CELL_H;
        if (dbl_en && (line == int'(dbl_line) || line == int'(dbl_line) + 1)) begin
            ras  = (src - int'(dbl_line) * CELL_H) / 2;
            line = int'(dbl_line);
        end
    end

    always_comb begin
        dd_addr    = shift_en ? DD_AW'(line * COLS + int'(col)) : '0;
        glyph_user = (int'(dd_code) < USER_GLYPHS);
        if (glyph_user)
            glyph_addr = GA_W'({dd_code[UG_W-1:0], RAS_W'(ras)});
        else
            glyph_addr = {dd_code, RAS_W'(ras)};
    end

endmodule

// File: rtl/lcdscan_latch.sv
module lcdscan_latch #(
    parameter int SEG_W   = 60,
    parameter int CELL_W  = 5,
    parameter int COM_W   = 34,
    localparam int ROW_W  = $clog2(COM_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [CELL_W-1:0] din,
    input  logic              tick,
    input  logic              disp_on,
    input  logic [ROW_W-1:0]  com_idx,
    output logic [SEG_W-1:0]  seg_out,
    output logic [COM_W-1:0]  com_out
);

    logic [SEG_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            seg_out <= '0;
            com_out <= '0;
        end else begin
            if (shift_en) sh_q <= {din, sh_q[SEG_W-1:CELL_W]};
            if (tick) begin
                seg_out <= disp_on ? sh_q : '0;
                com_out <= COM_W'(1) << com_idx;
            end
        end
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(seg_out) && $stable(com_out)));

    // R2
    onehot_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> ($countones(com_out) == 1));

    // R9
    blank_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !disp_on) |=> (seg_out == '0));

endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan import lcdscan_pkg::*; #(
    parameter int COLS        = DEF_COLS,
    parameter int CELL_W      = DEF_CELL_W,
    parameter int CELL_H      = DEF_CELL_H,
    parameter int MAX_LINES   = DEF_LINES,
    parameter int ICONS       = DEF_ICONS,
    parameter int USER_GLYPHS = DEF_USER,
    parameter int CODE_W      = DEF_CODE_W,
    parameter int ROW_CYCLES  = DEF_ROW_CYC,
    localparam int LSEL_W     = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1,
    localparam int GLYPH_ROWS = MAX_LINES * CELL_H,
    localparam int GR_W       = $clog2(GLYPH_ROWS),
    localparam int COM_W      = GLYPH_ROWS + 2,
    localparam int ROW_W      = $clog2(COM_W),
    localparam int SEG_W      = COLS * CELL_W,
    localparam int DD_AW      = $clog2(MAX_LINES * COLS),
    localparam int GA_W       = CODE_W + $clog2(CELL_H),
    localparam int IA_W       = $clog2(ICONS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LSEL_W-1:0] line_sel,
    input  logic              disp_on,
    input  logic [GR_W-1:0]   scroll,
    input  logic              dbl_en,
    input  logic [LSEL_W-1:0] dbl_line,
    output logic [DD_AW-1:0]  dd_addr,
    input  logic [CODE_W-1:0] dd_code,
    output logic              glyph_user,
    output logic [GA_W-1:0]   glyph_addr,
    input  logic [CELL_W-1:0] glyph_bits,
    output logic [IA_W-1:0]   icon_addr,
    input  logic [CELL_W-1:0] icon_bits,
    output logic [SEG_W-1:0]  seg_out,
    output logic [COM_W-1:0]  com_out
);

    scan_pos_t         pos;
    logic [ROW_W-1:0]  com_idx;
    logic [CELL_W-1:0] din;
    logic              icon_col;

    lcdscan_timing #(
        .COLS(COLS), .CELL_H(CELL_H), .MAX_LINES(MAX_LINES), .ROW_CYCLES(ROW_CYCLES)
    ) u_timing (
        .clk(clk), .rst(rst), .line_sel(line_sel), .pos(pos)
    );

    lcdscan_addr #(
        .COLS(COLS), .CELL_H(CELL_H), .MAX_LINES(MAX_LINES),
        .CODE_W(CODE_W), .USER_GLYPHS(USER_GLYPHS)
    ) u_addr (
        .glyph_row(pos.glyph_row), .col(pos.col), .shift_en(pos.shift_en),
        .scroll(scroll), .dbl_en(dbl_en), .dbl_line(dbl_line),
        .dd_code(dd_code), .dd_addr(dd_addr),
        .glyph_user(glyph_user), .glyph_addr(glyph_addr)
    );

    assign icon_col  = (int'(pos.col) < ICONS);
    assign icon_addr = icon_col ? IA_W'(pos.col) : '0;

    always_comb begin
        unique case (pos.kind)
            ROW_GLYPH: begin
                com_idx = ROW_W'(pos.glyph_row);
                din     = glyph_bits;
            end
            ROW_ICON_TOP: begin
                com_idx = ROW_W'(GLYPH_ROWS);
                din     = icon_col ? icon_bits : '0;
            end
            default: begin
                com_idx = ROW_W'(GLYPH_ROWS + 1);
                din     = icon_col ? icon_bits : '0;
            end
        endcase
    end

    lcdscan_latch #(
        .SEG_W(SEG_W), .CELL_W(CELL_W), .COM_W(COM_W)
    ) u_latch (
        .clk(clk), .rst(rst), .shift_en(pos.shift_en), .din(din),
        .tick(pos.tick), .disp_on(disp_on), .com_idx(com_idx),
        .seg_out(seg_out), .com_out(com_out)
    );

    generate
        if (ICONS * CELL_W < SEG_W) begin : g_icon_pad
            // R6
            icon_pad_chk: assert property (@(posedge clk) disable iff (rst)
                (com_out[GLYPH_ROWS] || com_out[GLYPH_ROWS+1]) |->
                (seg_out[SEG_W-1:ICONS*CELL_W] == '0));
        end
    endgenerate

    // R5
    user_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (pos.shift_en && pos.kind == ROW_GLYPH && glyph_user) |->
        (glyph_addr[GA_W-1:$clog2(USER_GLYPHS)+$clog2(CELL_H)] == '0));

endmodule

// File: tb/test_lcd_row_scan.sv
module test_lcd_row_scan;

    localparam int RC = 14;
    localparam int CH = 8;
    localparam int NCOL = 12;
    localparam int GR = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  line_sel = 2'd3;
    logic        disp_on = 1'b1;
    logic [4:0]  scroll = '0;
    logic        dbl_en = 1'b0;
    logic [1:0]  dbl_line = '0;
    logic [5:0]  dd_addr;
    logic [7:0]  dd_code;
    logic        glyph_user;
    logic [10:0] glyph_addr;
    logic [4:0]  glyph_bits;
    logic [2:0]  icon_addr;
    logic [4:0]  icon_bits;
    logic [59:0] seg_out;
    logic [33:0] com_out;

    logic [7:0] dd_mem   [0:63];
    logic [4:0] user_mem [0:31];
    logic [4:0] icon_mem [0:7];

    int          total = 0;
    int          bad = 0;
    int          fr = 0;
    bit          first_row = 1'b1;
    logic [33:0] prev_com = '0;

    always #5 clk = ~clk;

    function automatic logic [4:0] rom_pat(input logic [7:0] c, input int r);
        return 5'((int'(c) * 3 + r * 7 + 1) % 32);
    endfunction

    assign dd_code    = dd_mem[dd_addr];
    assign glyph_bits = glyph_user ? user_mem[glyph_addr[4:0]]
                                   : rom_pat(glyph_addr[10:3], int'(glyph_addr[2:0]));
    assign icon_bits  = icon_mem[icon_addr];

    lcd_row_scan #(.ROW_CYCLES(RC)) i_lcd_row_scan (
        .clk(clk), .rst(rst), .line_sel(line_sel), .disp_on(disp_on),
        .scroll(scroll), .dbl_en(dbl_en), .dbl_line(dbl_line),
        .dd_addr(dd_addr), .dd_code(dd_code), .glyph_user(glyph_user),
        .glyph_addr(glyph_addr), .glyph_bits(glyph_bits),
        .icon_addr(icon_addr), .icon_bits(icon_bits),
        .seg_out(seg_out), .com_out(com_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int n_rows();
        return (int'(line_sel) + 1) * CH + 2;
    endfunction

    function automatic logic [33:0] exp_com(input int row);
        int L;
        L = int'(line_sel) + 1;
        if (row == 0) return 34'(1) << 32;
        if (row <= L * CH) return 34'(1) << (row - 1);
        return 34'(1) << 33;
    endfunction

    function automatic logic [59:0] exp_seg(input int row);
        logic [59:0] v;
        logic [7:0]  code;
        int L, g, s, ln, r;
        v = '0;
        L = int'(line_sel) + 1;
        if (!disp_on) return '0;
        if (row == 0 || row > L * CH) begin
            for (int k = 0; k < 8; k++) v[5*k +: 5] = icon_mem[k];
        end else begin
            g  = row - 1;
            s  = (g + int'(scroll)) % GR;
            ln = s / CH;
            r  = s % CH;
            if (dbl_en && (ln == int'(dbl_line) || ln == int'(dbl_line) + 1)) begin
                r  = (s - int'(dbl_line) * CH) / 2;
                ln = int'(dbl_line);
            end
            for (int c = 0; c < NCOL; c++) begin
                code = dd_mem[ln * NCOL + c];
                v[5*c +: 5] = (code < 8'd4) ? user_mem[{code[1:0], 3'(r)}] : rom_pat(code, r);
            end
        end
        return v;
    endfunction

    // waits for the next row boundary and checks it against the model
    task automatic check_row(input string tag);
        int cyc;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (com_out == prev_com && cyc < 4 * RC);
        prev_com = com_out;
        if (cyc >= 4 * RC) begin
            chk(1'b0, {tag, " no row boundary"}, 64'(cyc), 64'(RC));
            return;
        end
        if (!first_row) chk(cyc == RC, {tag, " period"}, 64'(cyc), 64'(RC));
        first_row = 1'b0;
        chk(com_out == exp_com(fr), {tag, " com"}, 64'(com_out), 64'(exp_com(fr)));
        chk(seg_out == exp_seg(fr), {tag, " seg"}, 64'(seg_out), 64'(exp_seg(fr)));
        fr = (fr >= n_rows() - 1) ? 0 : fr + 1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(seg_out == '0, "R1 seg in reset", 64'(seg_out), 64'd0);
        chk(com_out == '0, "R1 com in reset", 64'(com_out), 64'd0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(seg_out == '0, "R1 seg before first row", 64'(seg_out), 64'd0);
        chk(com_out == '0, "R1 com before first row", 64'(com_out), 64'd0);
        prev_com = '0;
        fr = 0;
        first_row = 1'b1;
    endtask

    task automatic t_basic();
        for (int i = 0; i < 36; i++) check_row("R2 R3 R4 R6 four lines");
    endtask

    task automatic t_one_line();
        line_sel = 2'd0;
        for (int i = 0; i < 22; i++) check_row("R3 one line");
    endtask

    task automatic t_shrink();
        line_sel = 2'd3;
        while (fr != 25) check_row("R3 refill");
        line_sel = 2'd1;
        for (int i = 0; i < 4; i++) check_row("R10 shrink");
        line_sel = 2'd2;
        for (int i = 0; i < 28; i++) check_row("R3 three lines");
    endtask

    task automatic t_scroll();
        line_sel = 2'd1;
        scroll = 5'd13;
        for (int i = 0; i < 20; i++) check_row("R7 scroll 13");
        scroll = 5'd31;
        for (int i = 0; i < 20; i++) check_row("R7 scroll 31");
        scroll = '0;
    endtask

    task automatic t_double();
        line_sel = 2'd3;
        dbl_en = 1'b1;
        dbl_line = 2'd1;
        for (int i = 0; i < 36; i++) check_row("R8 double mid");
        dbl_line = 2'd3;
        scroll = 5'd6;
        for (int i = 0; i < 36; i++) check_row("R8 double last");
        dbl_en = 1'b0;
        scroll = '0;
    endtask

    task automatic t_user();
        for (int c = 0; c < 24; c++) dd_mem[c] = (c % 3 == 0) ? 8'(c % 4) : ((c % 3 == 1) ? 8'd4 : 8'd255);
        for (int i = 0; i < 36; i++) check_row("R5 user and fixed codes");
    endtask

    task automatic t_blank();
        disp_on = 1'b0;
        for (int i = 0; i < 12; i++) check_row("R9 blank");
        disp_on = 1'b1;
        for (int i = 0; i < 6; i++) check_row("R9 unblank");
    endtask

    task automatic t_icons();
        for (int k = 0; k < 8; k++) icon_mem[k] = 5'(31 - k * 2);
        for (int i = 0; i < 36; i++) check_row("R6 icon rows");
    endtask

    initial begin
        #2000000;
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) dd_mem[i] = 8'((i * 37 + 5) % 256);
        for (int i = 0; i < 32; i++) user_mem[i] = 5'((i * 11 + 17) % 32);
        for (int k = 0; k < 8; k++) icon_mem[k] = 5'(k * 3 + 2);
        t_reset();
        t_basic();
        t_one_line();
        t_shrink();
        t_scroll();
        t_double();
        t_user();
        t_blank();
        t_icons();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule